// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects single-cycle event pulses from up to sixteen device-side sources into a sticky status register and drives one interrupt line toward a host processor. The host reaches the block through a small word-addressed register port with a write strobe, a read strobe, a 3-bit word index and 32-bit data. Read data is combinational in the cycle that the read strobe is high. All register side effects take place at the next rising clock edge.

The host controls which sources may raise the line through a mask register. It can write the mask whole, or set or clear chosen bits through two dedicated write-only ports that leave the other bits alone. Status can be read in two ways: a read that has no side effect, and a read that returns the value and then empties the register. Single bits can also be retired through a write-one acknowledge port. A configuration register gates the output line and selects its polarity.

Only bits 0 to 10 and bit 14 have event sources. In order, they are: receive buffer A, transmit data, transmit transfer, receive buffer B, receive transfer, mailbox events A and B, wake, trace A and B, command done, and init done.

Top module: `host_irq_hub`

## Requirements
- R1: After reset the mask reads 0x0001, the status reads 0, the configuration reads 0, and the interrupt line `hostIrq` is low.
- R2: Word 0 is the mask. A write replaces bits 15:0 and a read returns them. A 1 in a mask bit keeps that status bit from raising the line.
- R3: A write to word 1 sets every mask bit whose data bit is 1. All other mask bits keep their value.
- R4: A write to word 2 clears every mask bit whose data bit is 1. All other mask bits keep their value.
- R5: A read of word 3 returns the status in bits 15:0 and changes nothing.
- R6: A read of word 4 returns the status in bits 15:0. At that clock edge every status bit is cleared.
- R7: A write to word 5 clears each status bit whose data bit is 1. The clear shows in both words 3 and 4. Data bits of 0 have no effect.
- R8: An event pulse on a bit in the same cycle as an acknowledge or a clear-on-read of that bit leaves the bit set.
- R9: Status bits 11, 12, 13 and 15 have no source. They always read 0, and events on them are ignored.
- R10: Word 6 is the configuration. Bit 5 enables the line and bit 7 selects active-low; all other bits read 0. While the line is disabled it sits at its inactive level: 0 for active-high, 1 for active-low.
- R11: While enabled, the line is active exactly when some status bit is 1 and its mask bit is 0. A mask, acknowledge, configuration or clear-on-read access shows on the line from the cycle after the access.
- R12: Reads of words 1, 2, 5 and 7 return 0. Writes to words 3, 4 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Word index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid while regRdEn is high |
| irqEvents | input | 16 | Event pulses from the sources, one bit per source |
| hostIrq | output | 1 | Interrupt line to the host |

## Verification
The assertions take for granted that the host raises at most one write strobe per cycle. They also assume that a clear-on-read can coincide with an acknowledge write, and that events may arrive on any bit, assigned or not. The bench keeps to this: each cycle it drives one word index, shared by read and write. It deliberately places event pulses in the same cycles as acknowledges and clear-on-read accesses, and it sends all-ones event words to reach the unassigned bits. A long pseudo-random phase mixes every address, data and event pattern against a behavioural model.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;

  // Word indices of the host register port
  localparam logic [2:0] ADR_MASK    = 3'd0;
  localparam logic [2:0] ADR_MSET    = 3'd1;
  localparam logic [2:0] ADR_MCLR    = 3'd2;
  localparam logic [2:0] ADR_STAT    = 3'd3;
  localparam logic [2:0] ADR_STATCOR = 3'd4;
  localparam logic [2:0] ADR_ACK     = 3'd5;
  localparam logic [2:0] ADR_CFG     = 3'd6;

  // Configuration bit positions
  localparam int CFG_EN_BIT  = 5;
  localparam int CFG_LOW_BIT = 7;

  // Source bit positions
  localparam int SRC_RXBUF_A   = 0;
  localparam int SRC_TXDATA    = 1;
  localparam int SRC_TXXFER    = 2;
  localparam int SRC_RXBUF_B   = 3;
  localparam int SRC_RXXFER    = 4;
  localparam int SRC_MBOX_A    = 5;
  localparam int SRC_MBOX_B    = 6;
  localparam int SRC_WAKE      = 7;
  localparam int SRC_TRACE_A   = 8;
  localparam int SRC_TRACE_B   = 9;
  localparam int SRC_CMD_DONE  = 10;
  localparam int SRC_INIT_DONE = 14;

  localparam logic [15:0] SRC_PRESENT =
      (16'd1 << SRC_RXBUF_A) | (16'd1 << SRC_TXDATA) | (16'd1 << SRC_TXXFER) |
      (16'd1 << SRC_RXBUF_B) | (16'd1 << SRC_RXXFER) | (16'd1 << SRC_MBOX_A) |
      (16'd1 << SRC_MBOX_B)  | (16'd1 << SRC_WAKE)   | (16'd1 << SRC_TRACE_A) |
      (16'd1 << SRC_TRACE_B) | (16'd1 << SRC_CMD_DONE) | (16'd1 << SRC_INIT_DONE);

  typedef struct packed {
    logic maskWr;
    logic maskSet;
    logic maskClr;
    logic ackWr;
    logic cfgWr;
    logic corRd;
  } strobe_t;

endpackage

// File: rtl/host_irq_decode.sv
module host_irq_decode
  import host_irq_pkg::*;
(
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  output strobe_t    strobes
);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADR_MASK: strobes.maskWr  = 1'b1;
        ADR_MSET: strobes.maskSet = 1'b1;
        ADR_MCLR: strobes.maskClr = 1'b1;
        ADR_ACK:  strobes.ackWr   = 1'b1;
        ADR_CFG:  strobes.cfgWr   = 1'b1;
        default: ;
      endcase
    end
    strobes.corRd = regRdEn && (regAddr == ADR_STATCOR);
  end

endmodule

// File: rtl/host_irq_datapath.sv
module host_irq_datapath
  import host_irq_pkg::*;
#(
  parameter int          NUM_SRC  = 16,
  parameter int          DATA_W   = 32,
  parameter logic [15:0] SRC_MAP  = SRC_PRESENT,
  parameter logic [15:0] MASK_RST = 16'h0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [2:0]         rdAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] events,
  output logic [DATA_W-1:0]  rdData,
  output logic               hostIrq
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] maskQ, statusQ, wrBits, clrBits, srcEvents;
  logic               cfgEnQ, cfgLowQ, irqPending;

  assign wrBits    = wrData[NUM_SRC-1:0];
  assign srcEvents = events & SRC_MAP[NUM_SRC-1:0];
  assign clrBits   = strobes.corRd ? '1 : (strobes.ackWr ? wrBits : '0);

  // Mask register
  always_ff @(posedge clk) begin
    if (!rstN)                maskQ <= MASK_RST[NUM_SRC-1:0];
    else if (strobes.maskWr)  maskQ <= wrBits;
    else if (strobes.maskSet) maskQ <= maskQ | wrBits;
    else if (strobes.maskClr) maskQ <= maskQ & ~wrBits;
  end

  // Status bits: only sourced positions get a flop
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    if (SRC_MAP[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN)             statusQ[i] <= 1'b0;
        else if (events[i])    statusQ[i] <= 1'b1;
        else if (clrBits[i])   statusQ[i] <= 1'b0;
      end
    end else begin : g_tie
      assign statusQ[i] = 1'b0;
    end
  end

  // Configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnQ  <= 1'b0;
      cfgLowQ <= 1'b0;
    end else if (strobes.cfgWr) begin
      cfgEnQ  <= wrData[CFG_EN_BIT];
      cfgLowQ <= wrData[CFG_LOW_BIT];
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_MASK:             rdData = {{PAD_W{1'b0}}, maskQ};
      ADR_STAT, ADR_STATCOR: rdData = {{PAD_W{1'b0}}, statusQ};
      ADR_CFG: begin
        rdData[CFG_EN_BIT]  = cfgEnQ;
        rdData[CFG_LOW_BIT] = cfgLowQ;
      end
      default: rdData = '0;
    endcase
  end

  assign irqPending = |(statusQ & ~maskQ);
  assign hostIrq    = cfgEnQ ? (irqPending ^ cfgLowQ) : cfgLowQ;

  // R3: set port leaves every written-one bit set
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskSet |=> ((maskQ & $past(wrBits)) == $past(wrBits)));

  // R4: clear port leaves every written-one bit clear
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskClr |=> ((maskQ & $past(wrBits)) == '0));

  // R6: clear-on-read with no new event empties status
  a_r6_cor_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.corRd && !(|srcEvents)) |=> (statusQ == '0));

  // R7: acknowledged bits without a new event are gone
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackWr |=> ((statusQ & $past(wrBits & ~srcEvents)) == '0));

  // R8: an event is never lost to a simultaneous clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvents) |=> ((statusQ & $past(srcEvents)) == $past(srcEvents)));

endmodule

// File: rtl/host_irq_hub.sv
module host_irq_hub
  import host_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] irqEvents,
  output logic               hostIrq
);

  strobe_t strobes;

  host_irq_decode u_decode (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  host_irq_datapath #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdAddr  (regAddr),
    .wrData  (regWrData),
    .events  (irqEvents),
    .rdData  (regRdData),
    .hostIrq (hostIrq)
  );

endmodule

// File: tb/host_irq_hub_tb.sv
module host_irq_hub_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] irqEvents = '0;
  logic        hostIrq;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state
  int mMask, mStat, mCfg;
  localparam int SRCMAP = 32'h47FF;

  always #5 clk = ~clk;

  host_irq_hub u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqEvents(irqEvents), .hostIrq(hostIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expIrq();
    bit en, low, pend;
    en   = mCfg[5];
    low  = mCfg[7];
    pend = ((mStat & ~mMask) & 32'hFFFF) != 0;
    return en ? int'(pend ^ low) : int'(low);
  endfunction

  function automatic int expRd(input int a);
    case (a)
      0: return mMask;
      3, 4: return mStat;
      6: return mCfg;
      default: return 0;
    endcase
  endfunction

  // One cycle: drive, check combinational outputs, then advance the model
  task automatic step(input bit we, input bit re, input int a, input int wd,
                      input int ev, input string tag);
    int clr;
    @(negedge clk);
    regWrEn = we; regRdEn = re; regAddr = a[2:0];
    regWrData = wd; irqEvents = ev[15:0];
    #2;
    check({tag, " line"}, int'(hostIrq), expIrq());
    if (re) check({tag, " read"}, int'(regRdData), expRd(a));
    @(posedge clk);
    clr = 0;
    if (we && a == 5) clr = wd & 32'hFFFF;
    if (re && a == 4) clr = 32'hFFFF;
    mStat = ((mStat & ~clr) | (ev & SRCMAP)) & 32'hFFFF;
    if (we) begin
      case (a)
        0: mMask = wd & 32'hFFFF;
        1: mMask = mMask | (wd & 32'hFFFF);
        2: mMask = mMask & ~wd & 32'hFFFF;
        6: mCfg  = wd & 32'hA0;
        default: ;
      endcase
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    mMask = 1; mStat = 0; mCfg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset line", int'(hostIrq), 0);
    step(0, 1, 0, 0, 0, "R1 mask reset");
    step(0, 1, 3, 0, 0, "R1 status reset");
    step(0, 1, 6, 0, 0, "R1 cfg reset");

    // R10: disabled line stays low with pending status
    step(0, 0, 0, 0, 32'h0002, "R10 event while disabled");
    idle("R10 disabled inactive");
    step(1, 0, 6, 32'hFFFF_FF7F, 0, "R10 enable high");
    step(0, 1, 6, 0, 0, "R10 cfg readback");
    idle("R11 line up");
    // R5: non-destructive read twice
    step(0, 1, 3, 0, 0, "R5 read a");
    step(0, 1, 3, 0, 0, "R5 read b");
    // R7: ack of bit 1, ack of zeros
    step(1, 0, 5, 32'h0000_0000, 0, "R7 ack zero");
    step(0, 1, 4 - 1, 0, 0, "R7 no effect");
    step(1, 0, 5, 32'h0000_0002, 0, "R7 ack bit");
    step(0, 1, 3, 0, 0, "R7 nd view");
    step(0, 1, 4, 0, 0, "R7 cor view");
    // R2: masked bit 0 blocks, unmask raises
    step(0, 0, 0, 0, 32'h0001, "R2 masked event");
    idle("R2 blocked");
    step(1, 0, 0, 32'h0000_0000, 0, "R2 unmask");
    idle("R11 after unmask");
    // R3 / R4 set and clear ports
    step(1, 0, 1, 32'h0000_8001, 0, "R3 set");
    step(0, 1, 0, 0, 0, "R3 readback");
    step(1, 0, 2, 32'h0000_8000, 0, "R4 clear");
    step(0, 1, 0, 0, 0, "R4 readback");
    step(1, 0, 2, 32'h0000_0001, 0, "R4 clear b0");
    idle("R11 mask clr effect");
    // R6 clear-on-read
    step(0, 0, 0, 0, 32'h4400, "R6 events");
    step(0, 1, 4, 0, 0, "R6 cor");
    step(0, 1, 3, 0, 0, "R6 emptied");
    // R8 event collides with ack and with cor
    step(0, 0, 0, 0, 32'h0010, "R8 prep");
    step(1, 0, 5, 32'h0000_0010, 32'h0010, "R8 ack collide");
    step(0, 1, 3, 0, 0, "R8 kept ack");
    step(0, 1, 4, 0, 32'h0020, "R8 cor collide");
    step(0, 1, 3, 0, 0, "R8 kept cor");
    // R9 unassigned bits
    step(1, 0, 5, 32'hFFFF, 0, "R9 flush");
    step(0, 0, 0, 0, 32'hB800, "R9 unassigned events");
    step(0, 1, 3, 0, 0, "R9 readback");
    step(0, 0, 0, 0, 32'hFFFF, "R9 all events");
    step(0, 1, 4, 0, 0, "R9 all readback");
    // R10 active-low, enabled then disabled
    step(0, 0, 0, 0, 32'h0004, "R10 event");
    step(1, 0, 6, 32'h0000_00A0, 0, "R10 active low");
    idle("R10 low asserted");
    step(1, 0, 6, 32'h0000_0080, 0, "R10 low disabled");
    idle("R10 low inactive");
    // R12 write-only / unused reads and read-only writes
    step(0, 1, 1, 0, 0, "R12 rd w1");
    step(0, 1, 2, 0, 0, "R12 rd w2");
    step(0, 1, 5, 0, 0, "R12 rd w5");
    step(0, 1, 7, 0, 0, "R12 rd w7");
    step(1, 0, 3, 32'hFFFF, 0, "R12 wr w3");
    step(1, 0, 4, 32'hFFFF, 0, "R12 wr w4");
    step(1, 0, 7, 32'hFFFF, 0, "R12 wr w7");
    step(0, 1, 3, 0, 0, "R12 status intact");
    step(0, 1, 0, 0, 0, "R12 mask intact");

    // Mixed pseudo-random phase
    seed = 7;
    for (int i = 0; i < 1500; i++) begin
      int r, a, ev;
      r  = $urandom(seed + i);
      a  = r & 7;
      ev = ((r >> 8) % 5 == 0) ? ($urandom & 32'hFFFF) : 0;
      step(r[3], r[4], a, $urandom, ev, "R11 random");
    end
    idle("R11 tail");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule